// File: doc/BRIEF.md
# Write-Per-Bit Mask Unit

This block forms the write-mask path of a nibble-wide DRAM write port. It watches the active-low row strobe, column strobe and write-enable, together with a mask-select level and a mask-load-cycle select. When the row strobe falls, it decides what kind of cycle is starting. The cycle can be an unmasked write, a masked write that takes a fresh mask from the data pins, a masked write that reuses the stored mask, or a cycle that only loads the mask register.

Inside an active row cycle, write data is captured on whichever falling edge comes later: the column strobe or write-enable. At that moment the block issues a one-clock write strobe, with a per-bit enable vector and the captured data, to the storage array that follows it. Because the stored mask persists, a whole run of writes can share one mask without reloading it every cycle. All strobes are sampled on a system clock, and an optional input synchronizer depth is chosen by parameter.

Top module: `wpb_mask_unit`

## Requirements
- R1: After reset, wr_stb is 0 and wr_be and wr_data are all zeros. The stored mask is all ones, so a masked write that reuses the mask enables every bit.
- R2: If we_n is high on the clock where ras_n is first seen low, the write in that row cycle enables all bits (wr_be all ones). The stored mask is left unchanged, whatever the level of dsf.
- R3: If we_n is low, dsf is low and mload_sel is low on the clock where ras_n is first seen low, the mask is reloaded from dq_in at that clock. The write in that row cycle uses the new mask.
- R4: If dsf is high on that clock, the mask is not reloaded and dq_in is ignored. Every masked write reuses the stored value until a later reload.
- R5: In a masked write, bit i of wr_be equals bit i of the mask. A 1 lets data bit i be written and a 0 blocks it.
- R6: Write data is captured from dq_in on the clock where the later of the two falling edges, cas_n or we_n, is seen inside the row cycle. wr_stb, wr_be and wr_data appear one clock later.
- R7: If mload_sel is high on the clock where ras_n is first seen low, the mask is loaded from dq_in. No write strobe is issued in that row cycle.
- R8: No write is issued if ras_n rises before both cas_n has fallen and we_n is low. No write is issued while ras_n is high.
- R9: Each cas_n low pulse inside a row cycle issues at most one write, and wr_stb is high for exactly one clock. Several cas_n pulses in one row cycle issue several writes with the same mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| dsf | input | 1 | Mask select: 0 reloads the mask, 1 keeps it |
| mload_sel | input | 1 | Selects a mask-load-only cycle when the row strobe falls |
| dq_in | input | DQ_W | Data pins: mask at row fall, write data at latch |
| wr_stb | output | 1 | One-clock write strobe to the array |
| wr_be | output | DQ_W | Per-bit write enables, 1 = write |
| wr_data | output | DQ_W | Captured write data |

## Verification
On every cycle, the embedded assertions check these rules:
- the mask reloads from the pins, or stays put, according to the levels sampled when the row strobe falls;
- in a masked cycle the enables equal the mask, and in an unmasked cycle they are all ones;
- no strobe occurs in a mask-load cycle;
- a strobe is never issued unless the row strobe was low, and it lasts one clock.

Only the directed scenarios can show the following:
- which edge actually captured the data in a late write;
- that an unmatched strobe edge issues nothing;
- that a mask survives many cycles and page-mode writes with the right values;
- the effect on a modelled storage word.

// File: rtl/wpb_pkg.sv
package wpb_pkg;

   typedef enum logic [1:0] {
      MODE_IDLE         = 2'd0,
      MODE_WRITE_ALL    = 2'd1,
      MODE_WRITE_MASKED = 2'd2,
      MODE_MASK_LOAD    = 2'd3
   } wpb_mode_e;

   // control strobes in one bundle, all active-low except the selects
   typedef struct packed {
      logic ras_n;
      logic cas_n;
      logic we_n;
      logic dsf;
      logic mload;
   } wpb_ctl_t;

   localparam int CTL_W = $bits(wpb_ctl_t);

   // idle level of the bundle: strobes high, selects low
   localparam wpb_ctl_t CTL_IDLE = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1,
                                     dsf: 1'b0, mload: 1'b0};

   function automatic wpb_mode_e pick_mode(input logic mload, input logic we_n);
      if (mload)      return MODE_MASK_LOAD;
      else if (we_n)  return MODE_WRITE_ALL;
      else            return MODE_WRITE_MASKED;
   endfunction

endpackage

// File: rtl/wpb_input_stage.sv
module wpb_input_stage #(
   parameter int             W       = 8,
   parameter int             STAGES  = 0,
   parameter logic [W-1:0]   IDLE    = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign dout = din;
      end else begin : g_sync
         logic [W-1:0] chain [STAGES];
         for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
               always_ff @(posedge clk) begin
                  if (!rst_n) chain[s] <= IDLE;
                  else        chain[s] <= din;
               end
            end else begin : g_next
               always_ff @(posedge clk) begin
                  if (!rst_n) chain[s] <= IDLE;
                  else        chain[s] <= chain[s-1];
               end
            end
         end
         assign dout = chain[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/wpb_edge_track.sv
module wpb_edge_track #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lvl_n,
   output logic [N-1:0] fall,
   output logic [N-1:0] rise
);

   logic [N-1:0] prev;

   generate
      for (genvar i = 0; i < N; i++) begin : g_bit
         always_ff @(posedge clk) begin
            if (!rst_n) prev[i] <= 1'b1;
            else        prev[i] <= lvl_n[i];
         end
         assign fall[i] =  prev[i] & ~lvl_n[i];
         assign rise[i] = ~prev[i] &  lvl_n[i];
      end
   endgenerate

endmodule

// File: rtl/wpb_cycle_ctrl.sv
module wpb_cycle_ctrl
   import wpb_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      ras_fall,
   input  logic      ras_rise,
   input  logic      we_n,
   input  logic      dsf,
   input  logic      mload,
   output logic      active,
   output wpb_mode_e mode,
   output logic      mask_load
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         mode   <= MODE_IDLE;
      end else if (ras_fall) begin
         active <= 1'b1;
         mode   <= pick_mode(mload, we_n);
      end else if (ras_rise) begin
         active <= 1'b0;
         mode   <= MODE_IDLE;
      end
   end

   // reload on a dedicated load cycle, or on a masked write with dsf low
   assign mask_load = ras_fall & (mload | (~we_n & ~dsf));

endmodule

// File: rtl/wpb_mask_reg.sv
module wpb_mask_reg #(
   parameter int            DQ_W       = 4,
   parameter logic [DQ_W-1:0] RESET_MASK = '1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [DQ_W-1:0] din,
   output logic [DQ_W-1:0] mask
);

   generate
      for (genvar i = 0; i < DQ_W; i++) begin : g_mbit
         always_ff @(posedge clk) begin
            if (!rst_n)    mask[i] <= RESET_MASK[i];
            else if (load) mask[i] <= din[i];
         end
      end
   endgenerate

endmodule

// File: rtl/wpb_write_gen.sv
module wpb_write_gen
   import wpb_pkg::*;
#(
   parameter int DQ_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            active,
   input  wpb_mode_e       mode,
   input  logic            ras_n,
   input  logic            cas_fall,
   input  logic            cas_rise,
   input  logic            we_n,
   input  logic [DQ_W-1:0] mask,
   input  logic [DQ_W-1:0] dq,
   output logic            wr_stb,
   output logic [DQ_W-1:0] wr_be,
   output logic [DQ_W-1:0] wr_data
);

   logic            armed;
   logic            write_cycle;
   logic            latch_ev;
   logic [DQ_W-1:0] be_next;

   assign write_cycle = (mode == MODE_WRITE_ALL) || (mode == MODE_WRITE_MASKED);
   assign latch_ev    = active & ~ras_n & write_cycle & (armed | cas_fall) & ~we_n;

   // armed: cas_n has fallen in this column cycle and no write left yet
   always_ff @(posedge clk) begin
      if (!rst_n)                  armed <= 1'b0;
      else if (!active || cas_rise) armed <= 1'b0;
      else if (latch_ev)           armed <= 1'b0;
      else if (cas_fall)           armed <= 1'b1;
   end

   generate
      for (genvar i = 0; i < DQ_W; i++) begin : g_be
         assign be_next[i] = (mode == MODE_WRITE_MASKED) ? mask[i] : 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_stb  <= 1'b0;
         wr_be   <= '0;
         wr_data <= '0;
      end else begin
         wr_stb <= latch_ev;
         if (latch_ev) begin
            wr_be   <= be_next;
            wr_data <= dq;
         end
      end
   end

   // R9: a strobe lasts one clock
   a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> !wr_stb);

   // R2: unmasked cycles enable every bit
   a_r2_full_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && mode == MODE_WRITE_ALL) |-> (wr_be == {DQ_W{1'b1}}));

   // R5: masked cycles enable exactly the mask bits
   a_r5_be_is_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && mode == MODE_WRITE_MASKED) |-> (wr_be == mask));

   // R7: a mask-load cycle never writes
   a_r7_no_write_on_load: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_MASK_LOAD) |-> !wr_stb);

endmodule

// File: rtl/wpb_mask_unit.sv
module wpb_mask_unit
   import wpb_pkg::*;
#(
   parameter int              DQ_W        = 4,
   parameter int              SYNC_STAGES = 0,
   parameter logic [DQ_W-1:0] RESET_MASK  = '1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ras_n,
   input  logic            cas_n,
   input  logic            we_n,
   input  logic            dsf,
   input  logic            mload_sel,
   input  logic [DQ_W-1:0] dq_in,
   output logic            wr_stb,
   output logic [DQ_W-1:0] wr_be,
   output logic [DQ_W-1:0] wr_data
);

   localparam int BUS_W = CTL_W + DQ_W;
   localparam logic [BUS_W-1:0] BUS_IDLE = {CTL_IDLE, {DQ_W{1'b0}}};

   generate
      if (DQ_W < 1 || DQ_W > 64) begin : g_bad_width
         $error("wpb_mask_unit: DQ_W must be within 1..64");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("wpb_mask_unit: SYNC_STAGES must be within 0..4");
      end
   endgenerate

   wpb_ctl_t        ctl_raw, ctl_s;
   logic [DQ_W-1:0] dq_s;
   logic [2:0]      strb_fall, strb_rise;
   logic            ras_fall, ras_rise, cas_fall, cas_rise;
   logic            active, mask_load;
   wpb_mode_e       mode;
   logic [DQ_W-1:0] mask;

   assign ctl_raw = '{ras_n: ras_n, cas_n: cas_n, we_n: we_n,
                      dsf: dsf, mload: mload_sel};

   wpb_input_stage #(.W(BUS_W), .STAGES(SYNC_STAGES), .IDLE(BUS_IDLE)) u_in (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({ctl_raw, dq_in}),
      .dout ({ctl_s, dq_s})
   );

   wpb_edge_track #(.N(3)) u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .lvl_n({ctl_s.ras_n, ctl_s.cas_n, ctl_s.we_n}),
      .fall (strb_fall),
      .rise (strb_rise)
   );

   assign ras_fall = strb_fall[2];
   assign ras_rise = strb_rise[2];
   assign cas_fall = strb_fall[1];
   assign cas_rise = strb_rise[1];

   wpb_cycle_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .ras_fall (ras_fall),
      .ras_rise (ras_rise),
      .we_n     (ctl_s.we_n),
      .dsf      (ctl_s.dsf),
      .mload    (ctl_s.mload),
      .active   (active),
      .mode     (mode),
      .mask_load(mask_load)
   );

   wpb_mask_reg #(.DQ_W(DQ_W), .RESET_MASK(RESET_MASK)) u_mask (
      .clk  (clk),
      .rst_n(rst_n),
      .load (mask_load),
      .din  (dq_s),
      .mask (mask)
   );

   wpb_write_gen #(.DQ_W(DQ_W)) u_wgen (
      .clk     (clk),
      .rst_n   (rst_n),
      .active  (active),
      .mode    (mode),
      .ras_n   (ctl_s.ras_n),
      .cas_fall(cas_fall),
      .cas_rise(cas_rise),
      .we_n    (ctl_s.we_n),
      .mask    (mask),
      .dq      (dq_s),
      .wr_stb  (wr_stb),
      .wr_be   (wr_be),
      .wr_data (wr_data)
   );

   // R3: masked write with dsf low takes the mask from the pins
   a_r3_reload_from_pins: assert property (@(posedge clk) disable iff (!rst_n)
      (ras_fall && !ctl_s.mload && !ctl_s.we_n && !ctl_s.dsf) |=> (mask == $past(dq_s)));

   // R4: dsf high keeps the stored mask
   a_r4_mask_persists: assert property (@(posedge clk) disable iff (!rst_n)
      (ras_fall && !ctl_s.mload && ctl_s.dsf) |=> $stable(mask));

   // R2: an unmasked write leaves the mask alone
   a_r2_mask_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (ras_fall && !ctl_s.mload && ctl_s.we_n) |=> $stable(mask));

   // R7: a load cycle takes the mask from the pins
   a_r7_load_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (ras_fall && ctl_s.mload) |=> (mask == $past(dq_s)));

   // R8: a strobe only follows a clock where the row strobe was low
   a_r8_needs_row: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> !$past(ctl_s.ras_n));

endmodule

// File: tb/sim_wpb_mask_unit.sv
`timescale 1ns/1ps
module sim_wpb_mask_unit;

   localparam int K_EARLY = 0, K_LATE = 1, K_CASONLY = 2, K_WONLY = 3, K_PAGE = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, dsf = 1'b0, mload_sel = 1'b0;
   logic [3:0] dq_in = 4'h0;
   logic       wr_stb;
   logic [3:0] wr_be, wr_data;

   int         n_chk = 0, n_bad = 0, n_stb = 0;
   logic [3:0] last_be = 4'h0, last_data = 4'h0, word = 4'h0;

   always #2.5 clk = ~clk;

   wpb_mask_unit u0 (
      .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .dsf(dsf), .mload_sel(mload_sel), .dq_in(dq_in),
      .wr_stb(wr_stb), .wr_be(wr_be), .wr_data(wr_data)
   );

   // behavioural storage word written through the enables
   always @(posedge clk) begin
      #1;
      if (wr_stb) begin
         n_stb++;
         last_be   = wr_be;
         last_data = wr_data;
         word      = (word & ~wr_be) | (wr_data & wr_be);
      end
   end

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   // one row cycle: levels at row fall, then the column/write pattern
   task automatic row_cycle(input logic w_at_ras, input logic dsf_v, input logic ml_v,
                            input logic [3:0] dq_ras, input logic [3:0] dq_cas,
                            input logic [3:0] dq_w, input int kind);
      ras_n = 1'b0; we_n = w_at_ras; dsf = dsf_v; mload_sel = ml_v; dq_in = dq_ras;
      step();
      dsf = 1'b0; mload_sel = 1'b0; dq_in = dq_cas;
      case (kind)
         K_EARLY: begin
            cas_n = 1'b0; step();
            cas_n = 1'b1; we_n = 1'b1; step();
         end
         K_LATE: begin
            we_n = 1'b1; cas_n = 1'b0; step();
            dq_in = dq_w; we_n = 1'b0; step();
            we_n = 1'b1; cas_n = 1'b1; step();
         end
         K_CASONLY: begin
            we_n = 1'b1; cas_n = 1'b0; step(); step();
            cas_n = 1'b1; step();
         end
         K_WONLY: begin
            cas_n = 1'b1; we_n = 1'b0; step(); step();
            we_n = 1'b1; step();
         end
         default: begin
            cas_n = 1'b0; step();
            cas_n = 1'b1; dq_in = dq_w; step();
            cas_n = 1'b0; step();
            cas_n = 1'b1; we_n = 1'b1; step();
         end
      endcase
      ras_n = 1'b1; dq_in = 4'h0; step(); step();
   endtask

   task automatic t_reset();
      check("R1 wr_stb after reset", wr_stb, 0);
      check("R1 wr_be after reset", wr_be, 0);
      check("R1 wr_data after reset", wr_data, 0);
      row_cycle(1'b0, 1'b1, 1'b0, 4'h0, 4'hA, 4'h0, K_EARLY);
      check("R1 reset mask enables all", last_be, 4'hF);
      check("R1 word", word, 4'hA);
   endtask

   task automatic t_write_all();
      int c0 = n_stb;
      row_cycle(1'b1, 1'b0, 1'b0, 4'h0, 4'h3, 4'h5, K_LATE);
      check("R2 one write", n_stb - c0, 1);
      check("R2 all enables", last_be, 4'hF);
      check("R2 word", word, 4'h5);
      row_cycle(1'b0, 1'b1, 1'b0, 4'h0, 4'hF, 4'h0, K_EARLY);
      check("R2 mask unchanged", last_be, 4'hF);
      check("R2 word after", word, 4'hF);
   endtask

   task automatic t_reload();
      row_cycle(1'b0, 1'b0, 1'b0, 4'h6, 4'h0, 4'h0, K_EARLY);
      check("R3 new mask used", last_be, 4'h6);
      check("R5 blocked bits kept", word, 4'h9);
   endtask

   task automatic t_persist();
      row_cycle(1'b0, 1'b1, 1'b0, 4'h9, 4'hF, 4'h0, K_EARLY);
      check("R4 mask persists", last_be, 4'h6);
      check("R4 word", word, 4'hF);
      row_cycle(1'b0, 1'b1, 1'b0, 4'h0, 4'h0, 4'h0, K_EARLY);
      check("R4 mask persists again", last_be, 4'h6);
      check("R5 word", word, 4'h9);
   endtask

   task automatic t_mask_load();
      int c0 = n_stb;
      row_cycle(1'b0, 1'b1, 1'b1, 4'h3, 4'h0, 4'h0, K_EARLY);
      check("R7 no write in load cycle", n_stb - c0, 0);
      check("R7 word untouched", word, 4'h9);
      row_cycle(1'b0, 1'b1, 1'b0, 4'h0, 4'h6, 4'h0, K_EARLY);
      check("R7 loaded mask used", last_be, 4'h3);
      check("R7 word", word, 4'hA);
   endtask

   task automatic t_late();
      int c0 = n_stb;
      row_cycle(1'b0, 1'b0, 1'b0, 4'hC, 4'h0, 4'hF, K_LATE);
      check("R6 one write", n_stb - c0, 1);
      check("R6 data at later edge", last_data, 4'hF);
      check("R6 mask", last_be, 4'hC);
      check("R6 word", word, 4'hE);
   endtask

   task automatic t_no_edge();
      int c0 = n_stb;
      row_cycle(1'b1, 1'b0, 1'b0, 4'h0, 4'h1, 4'h0, K_CASONLY);
      row_cycle(1'b1, 1'b0, 1'b0, 4'h0, 4'h1, 4'h0, K_WONLY);
      cas_n = 1'b0; we_n = 1'b0; dq_in = 4'h1; step(); step();
      cas_n = 1'b1; we_n = 1'b1; step();
      check("R8 no write without both edges", n_stb - c0, 0);
      check("R8 word untouched", word, 4'hE);
   endtask

   task automatic t_page();
      int c0 = n_stb;
      row_cycle(1'b0, 1'b1, 1'b0, 4'h0, 4'h0, 4'h8, K_PAGE);
      check("R9 two writes in page", n_stb - c0, 2);
      check("R9 same mask", last_be, 4'hC);
      check("R9 last data", last_data, 4'h8);
      check("R9 word", word, 4'hA);
   endtask

   initial begin
      #300000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (4) step();
      rst_n = 1'b1;
      step(); step();
      t_reset();
      t_write_all();
      t_reload();
      t_persist();
      t_mask_load();
      t_late();
      t_no_edge();
      t_page();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule